// File: doc/BRIEF.md
# Debug Event Router with Vector Catch

This block decides what happens to each debug event seen by a processor core. Five event sources arrive as single-cycle pulses: an executed breakpoint instruction, a comparator breakpoint hit, an external debug request, a halt command, and a vector-catch trap. A trap comes from per-class fault pulses or a core-reset pulse, each gated by its own catch enable. Each event goes to one of three places. It can raise a halt request that takes effect when the current instruction completes. It can set the pending flag of the monitor exception (exception number 12). A breakpoint instruction with no debug path enabled escalates to a hard fault.

The block holds the monitor-control register: trace enable, monitor enable, pend, step and request bits, and the catch enables. Its bits are split between two reset domains. The power-on reset clears everything. The system reset clears only the four monitor bits. A set of sticky debug-fault flags records why the core stopped or faulted. Software clears each flag by writing 1 to it.

The halt path is a three-state machine. RUN moves to WAIT_DONE when an event is routed to halt. WAIT_DONE moves to HALTED when `insn_done` is seen. HALTED moves back to RUN when `resume` is high and no new halt event arrives in the same cycle; if both occur together the core stays HALTED. Every output is registered and changes on the clock edge after the input that causes it.

Top module: `dbg_event_router`

## Requirements
- R1: After power-on reset, `cfg_rdata`, `dbg_status`, `halt_req`, `core_halted`, `mon_pend`, `hard_fault` and `trace_en` are all 0.
- R2: A write stores and reads back these control bits: trace enable at 24, monitor request at 19, monitor step at 18, monitor pend at 17 and monitor enable at 16. It also stores the catch enables for hard fault (10), exception-service error (9), bus fault (8), state error (7), checking error (6), no-coprocessor error (5), memory-management fault (4) and core reset (0). All other bits read 0, so writing all ones reads back 0x010F07F1. `fault_pulse[k]` is gated by the catch bit 4+k.
- R3: A system reset clears bits 19..16 and keeps bit 24 and the catch enables.
- R4: While `halt_en` is 1, a breakpoint instruction, a comparator hit, an external request or a halt command asserts `halt_req` in the next cycle and never sets the monitor pend.
- R5: `halt_req` stays high until `insn_done`. `core_halted` rises in the cycle after `insn_done`. `resume` while halted returns the core to run, unless a halt event arrives in the same cycle.
- R6: With `halt_en` 1, a fault pulse or core-reset pulse whose catch bit is set raises `halt_req`. A pulse of a class whose catch bit is clear has no effect.
- R7: With `halt_en` 0, catch pulses and halt commands raise no halt and set no flag.
- R8: With `halt_en` 0 and monitor enable 1, a breakpoint instruction, a comparator hit or an external request sets the pend bit and clears the request bit. A halt command has no effect.
- R9: A breakpoint instruction with `halt_en` 0 and monitor enable 0 gives a one-cycle `hard_fault` pulse and sets the breakpoint and debug-event flags. Comparator hits and external requests are then ignored.
- R10: The pend and request bits can be written directly, and `mon_pend` follows the pend bit. `mon_ack` clears the pend bit, but a routed monitor event in the same cycle wins.
- R11: `dbg_status` bit 0 is halt command, bit 1 is breakpoint, bit 2 is vector catch, bit 3 is external request and bit 4 is debug event. The flags are sticky. Writing 1 to a bit clears it, writing 0 has no effect, and a new set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset, clears monitor bits only |
| halt_en | input | 1 | Halt-mode debug enabled |
| cfg_we | input | 1 | Write strobe for the monitor-control register |
| cfg_wdata | input | 32 | Write data for the monitor-control register |
| cfg_rdata | output | 32 | Monitor-control register readback |
| sts_clr_we | input | 1 | Write strobe for the flag clear |
| sts_clr | input | 5 | Write-1-to-clear mask for the flags |
| ev_bkpt_insn | input | 1 | Breakpoint instruction executed |
| ev_cmp_bkpt | input | 1 | Comparator breakpoint hit |
| ev_ext_req | input | 1 | External debug request |
| ev_halt_cmd | input | 1 | Halt command |
| fault_pulse | input | 7 | Fault-class pulses: mem-mgmt, no-coproc, checking, state, bus, exc-service, hard |
| core_rst_evt | input | 1 | Core reset occurred |
| insn_done | input | 1 | Current instruction completes |
| resume | input | 1 | Leave the halted state |
| mon_ack | input | 1 | Monitor exception taken |
| halt_req | output | 1 | Halt requested, waiting for instruction completion |
| core_halted | output | 1 | Core halted |
| mon_pend | output | 1 | Monitor exception pending |
| hard_fault | output | 1 | Hard fault escalation pulse |
| trace_en | output | 1 | Trace system enable |
| dbg_status | output | 5 | Sticky debug-fault flags |

## Verification
Directed sequences drive each event source under each of the three enable combinations: halt on, monitor only, and neither. This separates halt routing, monitor routing and escalation, and shows that halt takes priority when both halt and monitor are enabled. The catch tests pulse an enabled class and a disabled class side by side, then repeat the pulses with halt debug off. This separates enable gating from the halt-mode gate. A long random phase then mixes overlapping events with register writes, system resets, acks, resumes and flag clears in the same cycle. This exercises the same-cycle priority orderings against a bench-side model.

// File: rtl/dbg_route_pkg.sv
package dbg_route_pkg;
    localparam int TRC_BIT  = 24;
    localparam int REQ_BIT  = 19;
    localparam int STEP_BIT = 18;
    localparam int PEND_BIT = 17;
    localparam int EN_BIT   = 16;
    localparam int VC_LSB   = 4;
    localparam int VCC_BIT  = 0;

    localparam int FL_HALT  = 0;
    localparam int FL_BKPT  = 1;
    localparam int FL_VCAT  = 2;
    localparam int FL_EXT   = 3;
    localparam int FL_DEVT  = 4;
    localparam int NFLAG    = 5;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_WAIT_DONE = 2'd1,
        ST_HALTED    = 2'd2
    } core_st_e;

    typedef struct packed {
        logic             to_halt;
        logic             to_mon;
        logic             to_fault;
        logic [NFLAG-1:0] flag_set;
    } route_t;
endpackage

// File: rtl/dbg_monctl_reg.sv
module dbg_monctl_reg
    import dbg_route_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NUM_FC = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              mon_ack,
    input  logic              hw_pend,
    output logic [DW-1:0]     rd_data,
    output logic              trace_q,
    output logic              mon_en_q,
    output logic              mon_pend_q,
    output logic [NUM_FC-1:0] vc_q,
    output logic              vcc_q
);
    logic step_q, req_q;
    logic en_n, pend_n, step_n, req_n;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // Debug domain: cleared by power-on reset only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            trace_q <= 1'b0;
            vc_q    <= '0;
            vcc_q   <= 1'b0;
        end else if (wr_en) begin
            trace_q <= wr_data[TRC_BIT];
            vc_q    <= wr_data[VC_LSB +: NUM_FC];
            vcc_q   <= wr_data[VCC_BIT];
        end
    end

    // Monitor bits: write, then ack, then hardware pend, then system reset
    always_comb begin
        en_n   = mon_en_q;
        pend_n = mon_pend_q;
        step_n = step_q;
        req_n  = req_q;
        if (wr_en) begin
            en_n   = wr_data[EN_BIT];
            pend_n = wr_data[PEND_BIT];
            step_n = wr_data[STEP_BIT];
            req_n  = wr_data[REQ_BIT];
        end
        if (mon_ack) pend_n = 1'b0;
        if (hw_pend) begin
            pend_n = 1'b1;
            req_n  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mon_en_q   <= 1'b0;
            mon_pend_q <= 1'b0;
            step_q     <= 1'b0;
            req_q      <= 1'b0;
        end else if (sys_rst) begin
            mon_en_q   <= 1'b0;
            mon_pend_q <= 1'b0;
            step_q     <= 1'b0;
            req_q      <= 1'b0;
        end else begin
            mon_en_q   <= en_n;
            mon_pend_q <= pend_n;
            step_q     <= step_n;
            req_q      <= req_n;
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[TRC_BIT]            = trace_q;
        rd_data[REQ_BIT]            = req_q;
        rd_data[STEP_BIT]           = step_q;
        rd_data[PEND_BIT]           = mon_pend_q;
        rd_data[EN_BIT]             = mon_en_q;
        rd_data[VC_LSB +: NUM_FC]   = vc_q;
        rd_data[VCC_BIT]            = vcc_q;
    end

    // R3: system reset clears the monitor group
    a_r3_sysrst_clears_mon: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (!mon_en_q && !mon_pend_q && !step_q && !req_q));
    // R3: system reset leaves the debug domain alone
    a_r3_sysrst_keeps_dbg: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && !wr_en) |=> ($stable(trace_q) && $stable(vc_q) && $stable(vcc_q)));
    // R10: ack clears pend when nothing re-pends it
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!por_n)
        (mon_ack && !hw_pend && !wr_en) |=> !mon_pend_q);
endmodule

// File: rtl/dbg_event_route.sv
module dbg_event_route
    import dbg_route_pkg::*;
#(
    parameter int NUM_FC = 7
) (
    input  logic              halt_en,
    input  logic              mon_en,
    input  logic              ev_bkpt_insn,
    input  logic              ev_cmp_bkpt,
    input  logic              ev_ext_req,
    input  logic              ev_halt_cmd,
    input  logic [NUM_FC-1:0] fault_pulse,
    input  logic [NUM_FC-1:0] vc_en,
    input  logic              core_rst_evt,
    input  logic              vcc_en,
    output route_t            rt
);
    logic [NUM_FC-1:0] class_hit;
    logic caught, bp, dbg_on;

    for (genvar k = 0; k < NUM_FC; k++) begin : g_catch
        assign class_hit[k] = fault_pulse[k] & vc_en[k];
    end

    always_comb begin
        caught = (|class_hit) | (core_rst_evt & vcc_en);
        bp     = ev_bkpt_insn | ev_cmp_bkpt;
        dbg_on = halt_en | mon_en;

        rt.to_halt  = halt_en & (bp | ev_ext_req | ev_halt_cmd | caught);
        rt.to_mon   = ~halt_en & mon_en & (bp | ev_ext_req);
        rt.to_fault = ~halt_en & ~mon_en & ev_bkpt_insn;

        rt.flag_set          = '0;
        rt.flag_set[FL_HALT] = halt_en & ev_halt_cmd;
        rt.flag_set[FL_BKPT] = (bp & dbg_on) | rt.to_fault;
        rt.flag_set[FL_VCAT] = halt_en & caught;
        rt.flag_set[FL_EXT]  = ev_ext_req & dbg_on;
        rt.flag_set[FL_DEVT] = rt.to_fault;
    end
endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
    import dbg_route_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic go_halt,
    input  logic insn_done,
    input  logic resume,
    output logic halt_req,
    output logic core_halted
);
    core_st_e st_q, st_n;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= ST_RUN;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_RUN:       if (go_halt)             st_n = ST_WAIT_DONE;
            ST_WAIT_DONE: if (insn_done)           st_n = ST_HALTED;
            ST_HALTED:    if (resume && !go_halt)  st_n = ST_RUN;
            default:                               st_n = ST_RUN;
        endcase
    end

    always_comb begin
        halt_req    = (st_q == ST_WAIT_DONE);
        core_halted = (st_q == ST_HALTED);
    end

    // R5: request holds until the instruction completes
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (!por_n)
        (halt_req && !insn_done) |=> (halt_req && !core_halted));
    // R5: completion moves to halted
    a_r5_done_halts: assert property (@(posedge clk) disable iff (!por_n)
        (halt_req && insn_done) |=> core_halted);
endmodule

// File: rtl/dbg_fault_flags.sv
module dbg_fault_flags #(
    parameter int NF = 5
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic [NF-1:0] set_in,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_mask,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                      q <= 1'b0;
            else if (set_in[i])              q <= 1'b1;
            else if (clr_we && clr_mask[i])  q <= 1'b0;
        end
        assign flags[i] = q;

        // R11: a flag only drops on a write-1 clear
        a_r11_sticky: assert property (@(posedge clk) disable iff (!por_n)
            (q && !(clr_we && clr_mask[i])) |=> q);
    end
endmodule

// File: rtl/dbg_event_router.sv
module dbg_event_router
    import dbg_route_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NUM_FC = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              halt_en,
    input  logic              cfg_we,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              sts_clr_we,
    input  logic [NFLAG-1:0]  sts_clr,
    input  logic              ev_bkpt_insn,
    input  logic              ev_cmp_bkpt,
    input  logic              ev_ext_req,
    input  logic              ev_halt_cmd,
    input  logic [NUM_FC-1:0] fault_pulse,
    input  logic              core_rst_evt,
    input  logic              insn_done,
    input  logic              resume,
    input  logic              mon_ack,
    output logic              halt_req,
    output logic              core_halted,
    output logic              mon_pend,
    output logic              hard_fault,
    output logic              trace_en,
    output logic [NFLAG-1:0]  dbg_status
);
    logic              mon_en_q, vcc_q;
    logic [NUM_FC-1:0] vc_q;
    route_t            rt;

    dbg_monctl_reg #(.DW(DW), .NUM_FC(NUM_FC)) u_reg (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst),
        .wr_en(cfg_we), .wr_data(cfg_wdata), .mon_ack(mon_ack),
        .hw_pend(rt.to_mon), .rd_data(cfg_rdata), .trace_q(trace_en),
        .mon_en_q(mon_en_q), .mon_pend_q(mon_pend), .vc_q(vc_q), .vcc_q(vcc_q)
    );

    dbg_event_route #(.NUM_FC(NUM_FC)) u_route (
        .halt_en(halt_en), .mon_en(mon_en_q),
        .ev_bkpt_insn(ev_bkpt_insn), .ev_cmp_bkpt(ev_cmp_bkpt),
        .ev_ext_req(ev_ext_req), .ev_halt_cmd(ev_halt_cmd),
        .fault_pulse(fault_pulse), .vc_en(vc_q),
        .core_rst_evt(core_rst_evt), .vcc_en(vcc_q), .rt(rt)
    );

    dbg_halt_fsm u_fsm (
        .clk(clk), .por_n(por_n), .go_halt(rt.to_halt),
        .insn_done(insn_done), .resume(resume),
        .halt_req(halt_req), .core_halted(core_halted)
    );

    dbg_fault_flags #(.NF(NFLAG)) u_flags (
        .clk(clk), .por_n(por_n), .set_in(rt.flag_set),
        .clr_we(sts_clr_we), .clr_mask(sts_clr), .flags(dbg_status)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) hard_fault <= 1'b0;
        else        hard_fault <= rt.to_fault;
    end

    // R9: escalation only when both debug paths are off
    a_r9_no_fault_when_enabled: assert property (@(posedge clk) disable iff (!por_n)
        (ev_bkpt_insn && (halt_en || mon_en_q)) |=> !hard_fault);
    // R9: escalation pulses and records its cause
    a_r9_escalate: assert property (@(posedge clk) disable iff (!por_n)
        (ev_bkpt_insn && !halt_en && !mon_en_q) |=>
            (hard_fault && dbg_status[FL_BKPT] && dbg_status[FL_DEVT]));
    // R4: halt path wins over the monitor path
    a_r4_halt_blocks_mon: assert property (@(posedge clk) disable iff (!por_n)
        (halt_en && !mon_pend && !cfg_we && (ev_bkpt_insn || ev_cmp_bkpt || ev_ext_req))
            |=> (!mon_pend && (halt_req || core_halted)));
    // R8: monitor routing pends the exception
    a_r8_mon_pend_set: assert property (@(posedge clk) disable iff (!por_n)
        (!halt_en && mon_en_q && ev_ext_req && !sys_rst) |=> mon_pend);
    // R7: no halt is started while halt debug is off
    a_r7_no_halt_when_off: assert property (@(posedge clk) disable iff (!por_n)
        (!halt_en && !halt_req) |=> !halt_req);
endmodule

// File: tb/tb_dbg_event_router.sv
`timescale 1ns/1ps
module tb_dbg_event_router;
    logic        clk = 1'b0;
    logic        por_n, sys_rst, halt_en, cfg_we, sts_clr_we;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [4:0]  sts_clr, dbg_status;
    logic        ev_bkpt_insn, ev_cmp_bkpt, ev_ext_req, ev_halt_cmd;
    logic [6:0]  fault_pulse;
    logic        core_rst_evt, insn_done, resume, mon_ack;
    logic        halt_req, core_halted, mon_pend, hard_fault, trace_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    bit       m_tr, m_req, m_step, m_pend, m_en, m_vcc, m_hf;
    bit [6:0] m_vc;
    bit [4:0] m_sts;
    int       m_st;

    always #10 clk = ~clk;

    dbg_event_router dut (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .halt_en(halt_en),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .sts_clr_we(sts_clr_we), .sts_clr(sts_clr),
        .ev_bkpt_insn(ev_bkpt_insn), .ev_cmp_bkpt(ev_cmp_bkpt),
        .ev_ext_req(ev_ext_req), .ev_halt_cmd(ev_halt_cmd),
        .fault_pulse(fault_pulse), .core_rst_evt(core_rst_evt),
        .insn_done(insn_done), .resume(resume), .mon_ack(mon_ack),
        .halt_req(halt_req), .core_halted(core_halted), .mon_pend(mon_pend),
        .hard_fault(hard_fault), .trace_en(trace_en), .dbg_status(dbg_status)
    );

    function automatic logic [31:0] exp_rdata();
        logic [31:0] r = '0;
        r[24] = m_tr; r[19] = m_req; r[18] = m_step; r[17] = m_pend;
        r[16] = m_en; r[10:4] = m_vc; r[0] = m_vcc;
        return r;
    endfunction

    function automatic logic [41:0] exp_vec();
        return {exp_rdata(), m_st == 1, m_st == 2, m_pend, m_hf, m_tr, m_sts};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        sys_rst = 0; cfg_we = 0; cfg_wdata = 0; sts_clr_we = 0; sts_clr = 0;
        ev_bkpt_insn = 0; ev_cmp_bkpt = 0; ev_ext_req = 0; ev_halt_cmd = 0;
        fault_pulse = 0; core_rst_evt = 0; insn_done = 0; resume = 0; mon_ack = 0;
    endtask

    task automatic model_reset();
        m_tr = 0; m_req = 0; m_step = 0; m_pend = 0; m_en = 0; m_vcc = 0;
        m_hf = 0; m_vc = 0; m_sts = 0; m_st = 0;
    endtask

    // one clock: predict, advance, compare all outputs
    task automatic tick(string tag);
        bit bp, caught, gh, gm, gf;
        bit [4:0] fs;
        bp     = ev_bkpt_insn | ev_cmp_bkpt;
        caught = (|(fault_pulse & m_vc)) | (core_rst_evt & m_vcc);
        gh = halt_en & (bp | ev_ext_req | ev_halt_cmd | caught);
        gm = !halt_en & m_en & (bp | ev_ext_req);
        gf = !halt_en & !m_en & ev_bkpt_insn;
        fs = '0;
        fs[0] = halt_en & ev_halt_cmd;
        fs[1] = (bp & (halt_en | m_en)) | gf;
        fs[2] = halt_en & caught;
        fs[3] = ev_ext_req & (halt_en | m_en);
        fs[4] = gf;
        @(posedge clk);
        #1;
        if (cfg_we) begin
            m_tr = cfg_wdata[24]; m_vc = cfg_wdata[10:4]; m_vcc = cfg_wdata[0];
            m_en = cfg_wdata[16]; m_pend = cfg_wdata[17];
            m_step = cfg_wdata[18]; m_req = cfg_wdata[19];
        end
        if (mon_ack) m_pend = 0;
        if (gm) begin m_pend = 1; m_req = 0; end
        if (sys_rst) begin m_en = 0; m_pend = 0; m_step = 0; m_req = 0; end
        case (m_st)
            0: if (gh) m_st = 1;
            1: if (insn_done) m_st = 2;
            default: if (resume && !gh) m_st = 0;
        endcase
        m_sts = (m_sts & ~(sts_clr_we ? sts_clr : 5'b0)) | fs;
        m_hf  = gf;
        checks++;
        if ({cfg_rdata, halt_req, core_halted, mon_pend, hard_fault, trace_en, dbg_status}
                !== exp_vec()) begin
            errors++;
            $display("FAIL %s model: actual=%h expected=%h", tag,
                {cfg_rdata, halt_req, core_halted, mon_pend, hard_fault, trace_en, dbg_status},
                exp_vec());
        end
    endtask

    task automatic wr_cfg(logic [31:0] v, string tag);
        cfg_we = 1; cfg_wdata = v; tick(tag); cfg_we = 0; cfg_wdata = 0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle(); halt_en = 0; por_n = 0; model_reset();
        repeat (3) @(posedge clk);
        #1 por_n = 1;
        // R1 reset state
        chk("R1 rdata", cfg_rdata, 0);
        chk("R1 outs", {halt_req, core_halted, mon_pend, hard_fault, trace_en, dbg_status}, 0);

        // R2 layout
        wr_cfg(32'hFFFF_FFFF, "R2");
        chk("R2 all ones", cfg_rdata, 32'h010F_07F1);
        chk("R2 trace_en", trace_en, 1);
        wr_cfg(32'h0000_0110, "R2");
        chk("R2 partial", cfg_rdata, 32'h0000_0110);

        // R3 system reset domain split
        wr_cfg(32'h010F_07F1, "R3");
        sys_rst = 1; tick("R3"); sys_rst = 0;
        chk("R3 sysrst", cfg_rdata, 32'h0100_07F1);
        chk("R3 pend", mon_pend, 0);

        // R4 halt priority over monitor
        wr_cfg(32'h0001_0000, "R4");
        halt_en = 1; ev_cmp_bkpt = 1; tick("R4"); ev_cmp_bkpt = 0;
        chk("R4 halt_req", halt_req, 1);
        chk("R4 no pend", mon_pend, 0);
        chk("R4 bkpt flag", dbg_status, 5'b00010);

        // R5 halt after instruction, resume
        tick("R5"); tick("R5");
        chk("R5 still waiting", {halt_req, core_halted}, 2'b10);
        insn_done = 1; tick("R5"); insn_done = 0;
        chk("R5 halted", {halt_req, core_halted}, 2'b01);
        resume = 1; ev_halt_cmd = 1; tick("R5"); ev_halt_cmd = 0;
        chk("R5 resume blocked", core_halted, 1);
        tick("R5"); resume = 0;
        chk("R5 resumed", {halt_req, core_halted}, 2'b00);

        // R6 vector catch, bus class enabled only
        wr_cfg(32'h0001_0100, "R6");
        fault_pulse = 7'b000_1000; tick("R6"); fault_pulse = 0;
        chk("R6 disabled class", halt_req, 0);
        fault_pulse = 7'b001_0000; tick("R6"); fault_pulse = 0;
        chk("R6 enabled class", halt_req, 1);
        chk("R6 vcatch flag", dbg_status[2], 1);
        insn_done = 1; tick("R6"); insn_done = 0;
        resume = 1; tick("R6"); resume = 0;
        wr_cfg(32'h0000_0001, "R6");
        core_rst_evt = 1; tick("R6"); core_rst_evt = 0;
        chk("R6 core reset catch", halt_req, 1);
        insn_done = 1; tick("R6"); insn_done = 0;
        resume = 1; tick("R6"); resume = 0;

        // R7 catch ignored with halt debug off
        halt_en = 0; wr_cfg(32'h0000_07F1, "R7");
        sts_clr_we = 1; sts_clr = 5'h1F; tick("R7"); sts_clr_we = 0; sts_clr = 0;
        fault_pulse = 7'h7F; core_rst_evt = 1; ev_halt_cmd = 1; tick("R7");
        fault_pulse = 0; core_rst_evt = 0; ev_halt_cmd = 0;
        chk("R7 no halt", {halt_req, core_halted}, 0);
        chk("R7 no flags", dbg_status, 0);

        // R8 monitor routing
        wr_cfg(32'h0009_0000, "R8");
        ev_ext_req = 1; tick("R8"); ev_ext_req = 0;
        chk("R8 pend set req cleared", cfg_rdata, 32'h0003_0000);
        chk("R8 ext flag", dbg_status, 5'b01000);
        ev_halt_cmd = 1; tick("R8"); ev_halt_cmd = 0;
        chk("R8 halt cmd ignored", {halt_req, dbg_status}, 6'b001000);

        // R10 manual pend and ack
        mon_ack = 1; tick("R10"); mon_ack = 0;
        chk("R10 ack", mon_pend, 0);
        wr_cfg(32'h000A_0000, "R10");
        chk("R10 manual", {mon_pend, cfg_rdata}, {1'b1, 32'h000A_0000});
        mon_ack = 1; tick("R10"); mon_ack = 0;
        chk("R10 ack keeps req", cfg_rdata, 32'h0008_0000);

        // R9 escalation
        wr_cfg(32'h0, "R9");
        sts_clr_we = 1; sts_clr = 5'h1F; tick("R9"); sts_clr_we = 0; sts_clr = 0;
        ev_cmp_bkpt = 1; ev_ext_req = 1; tick("R9"); ev_cmp_bkpt = 0; ev_ext_req = 0;
        chk("R9 cmp ignored", {hard_fault, dbg_status}, 0);
        ev_bkpt_insn = 1; tick("R9"); ev_bkpt_insn = 0;
        chk("R9 hard fault", hard_fault, 1);
        chk("R9 flags", dbg_status, 5'b10010);
        tick("R9");
        chk("R9 pulse ends", hard_fault, 0);

        // R11 write-1 clear
        sts_clr_we = 1; sts_clr = 5'b00010; tick("R11");
        chk("R11 clear one", dbg_status, 5'b10000);
        sts_clr = 5'b00000; tick("R11"); sts_clr_we = 0;
        chk("R11 zero write", dbg_status, 5'b10000);
        tick("R11");
        chk("R11 sticky", dbg_status, 5'b10000);

        // random mix: R4 R5 R6 R8 R9 R10 R11 against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(49) == 0) halt_en = ~halt_en;
            ev_bkpt_insn = ($urandom_range(7) == 0);
            ev_cmp_bkpt  = ($urandom_range(9) == 0);
            ev_ext_req   = ($urandom_range(9) == 0);
            ev_halt_cmd  = ($urandom_range(9) == 0);
            fault_pulse  = ($urandom_range(5) == 0) ? 7'($urandom()) : 7'b0;
            core_rst_evt = ($urandom_range(19) == 0);
            cfg_we       = ($urandom_range(19) == 0);
            cfg_wdata    = $urandom();
            sys_rst      = ($urandom_range(39) == 0);
            mon_ack      = ($urandom_range(9) == 0);
            insn_done    = ($urandom_range(2) == 0);
            resume       = ($urandom_range(5) == 0);
            sts_clr_we   = ($urandom_range(14) == 0);
            sts_clr      = 5'($urandom());
            tick("R4 R6 R8 R9 R11 random");
        end
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule